// File: doc/BRIEF.md
# Serial Frame Receiver with Error Flags

This block turns an asynchronous NRZ receive line into parallel characters. A 16x oversampling tick comes from outside the block. On each tick a small state machine looks for a start edge, checks that the start bit is real, and samples each data bit, an optional parity bit and the first stop bit at the centre of the bit. The configuration inputs select a character of 5 to 8 bits and one of four parity treatments. The receiver shares these inputs with the transmitter.

A finished character goes into a holding register, and the full flag is raised. The full flag stays up until the host strobes a read. Parity, framing and overrun errors are sticky. Reading the data does not clear them. They clear only when a character arrives with no error after a read has been made. Reception runs only while the terminal-ready enable is high and the active-low carrier-detect input is low. An echo mode drives the received line back out so that a transmit pin can carry it.

Top module: `serial_rx_core`

## Requirements
- R1: Data bits are taken least significant bit first, and the received value is right-aligned in `rdata` with the unused upper bits zero. The `wlen_sel` encoding is 00 = 8 bits, 01 = 7 bits, 10 = 6 bits and 11 = 5 bits.
- R2: A falling edge on the line starts a candidate start bit. If the line is high on the eighth tick after that edge, the edge is taken as noise: no character is produced, and a later valid frame is still received.
- R3: When `par_en` is 1, one parity bit follows the last data bit. With `par_mode` 00 (odd), `perr` sets when data plus parity has an even number of ones. With `par_mode` 01 (even), `perr` sets when that count is odd.
- R4: With `par_mode` 10 (mark) or 11 (space), the parity bit is received but never sets `perr`, whatever its value.
- R5: `ferr` sets when the first stop bit is sampled low. The character is still loaded.
- R6: `rx_full` rises only when a character is transferred to `rdata`. A one-cycle `rd_strobe` clears it at the next clock edge.
- R7: If a character completes while `rx_full` is set, `ovr` sets, `rdata` keeps the old character, and the new one is dropped.
- R8: `perr`, `ferr` and `ovr` do not change on a read. After a read has occurred, they all clear when the next character with no parity or framing error is loaded.
- R9: While `dcd_n` is high, the receiver stays idle and no character is produced.
- R10: While `term_en` is 0, the receiver stays idle and no character is produced.
- R11: `echo_txd` follows the synchronized receive line when `echo_en` is 1 and reception is enabled. Otherwise it is held high.
- R12: After reset, `rx_full`, `perr`, `ferr` and `ovr` are 0 and `echo_txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| dcd_n | input | 1 | Carrier detect, active low; gates reception |
| term_en | input | 1 | Terminal-ready enable; 0 disables reception |
| echo_en | input | 1 | Drive the received line back out on `echo_txd` |
| wlen_sel | input | 2 | Character length select |
| par_en | input | 1 | A parity bit is present in the frame |
| par_mode | input | 2 | Parity treatment: odd, even, mark, space |
| rd_strobe | input | 1 | Read of the receive data register |
| rdata | output | 8 | Received character |
| rx_full | output | 1 | Receive data register holds an unread character |
| perr | output | 1 | Sticky parity error |
| ferr | output | 1 | Sticky framing error |
| ovr | output | 1 | Sticky overrun |
| echo_txd | output | 1 | Echo output line |

## Verification
The line passes through a two-stage synchronizer. The state machine then samples the stop bit at its centre tick and emits a registered completion pulse, so `rdata`, `rx_full` and the error flags all change one edge after that pulse. That edge falls roughly half a bit after the stop bit starts. A monitor watches at falling clock edges for the rise of `rx_full` and compares the loaded character and flags against the queued expectation. The driver only issues a read once a full bit time has passed after the stop bit. A read clears `rx_full` at the next rising edge, and the bench checks it at the falling edge after that. `echo_txd` lags `rxd` by the two synchronizer cycles, so the bench samples it three cycles after a change. Checks that something was ignored wait for at least two bit times after the ignored stimulus ends.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Parity treatment; encoding is visible at the par_mode port
  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              pbad,
  output logic              fbad
);

  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int IW    = $clog2(DATA_W) + 1;
  localparam logic [IW-1:0]    DW_L      = IW'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_CHECK = CNT_W'(HALF - 1);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              px_q, px_d;
  logic              pe_q, pe_d;
  logic              prev_q, prev_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pbad_q, pbad_d;
  logic              fbad_q, fbad_d;
  logic [IW-1:0]     nbits;
  logic              last_tick;
  par_mode_e         pmode;

  assign nbits     = DW_L - IW'(wlen_sel);
  assign last_tick = (cnt_q == CNT_LAST);
  assign pmode     = par_mode_e'(par_mode);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    px_d   = px_q;
    pe_d   = pe_q;
    prev_d = prev_q;
    done_d = 1'b0;
    data_d = data_q;
    pbad_d = pbad_q;
    fbad_d = fbad_q;
    if (!rx_en) begin
      st_d   = RX_IDLE;
      cnt_d  = '0;
      prev_d = 1'b0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          prev_d = rxd;
          cnt_d  = '0;
          if (prev_q && !rxd) st_d = RX_START;
        end
        RX_START: begin
          if (cnt_q == CNT_CHECK) begin
            cnt_d = '0;
            if (rxd) begin
              st_d   = RX_IDLE;
              prev_d = 1'b1;
            end else begin
              st_d  = RX_DATA;
              idx_d = '0;
              px_d  = 1'b0;
              pe_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (last_tick) begin
            cnt_d = '0;
            sh_d  = {rxd, sh_q[DATA_W-1:1]};
            px_d  = px_q ^ rxd;
            idx_d = idx_q + IW'(1);
            if (idx_q == nbits - IW'(1)) st_d = par_en ? RX_PAR : RX_STOP;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_PAR: begin
          if (last_tick) begin
            cnt_d = '0;
            st_d  = RX_STOP;
            case (pmode)
              PAR_ODD:  pe_d = ~(px_q ^ rxd);
              PAR_EVEN: pe_d = px_q ^ rxd;
              default:  pe_d = 1'b0;
            endcase
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (last_tick) begin
            cnt_d  = '0;
            st_d   = RX_IDLE;
            prev_d = rxd;
            done_d = 1'b1;
            data_d = sh_q >> (DW_L - nbits);
            pbad_d = pe_q;
            fbad_d = ~rxd;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      px_q   <= 1'b0;
      pe_q   <= 1'b0;
      prev_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      pbad_q <= 1'b0;
      fbad_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      px_q   <= px_d;
      pe_q   <= pe_d;
      prev_q <= prev_d;
      done_q <= done_d;
      data_q <= data_d;
      pbad_q <= pbad_d;
      fbad_q <= fbad_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign pbad = pbad_q;
  assign fbad = fbad_q;

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_pbad,
  input  logic              d_fbad,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_full,
  output logic              perr,
  output logic              ferr,
  output logic              ovr
);

  logic [DATA_W-1:0] data_q, data_d;
  logic full_q, full_d;
  logic perr_q, perr_d;
  logic ferr_q, ferr_d;
  logic ovr_q, ovr_d;
  logic arm_q, arm_d;
  logic full_eff;

  assign full_eff = full_q & ~rd_strobe;

  always_comb begin
    data_d = data_q;
    full_d = full_eff;
    perr_d = perr_q;
    ferr_d = ferr_q;
    ovr_d  = ovr_q;
    arm_d  = arm_q | rd_strobe;
    if (done) begin
      if (full_eff) begin
        ovr_d = 1'b1;
      end else begin
        data_d = d_data;
        full_d = 1'b1;
        if (d_pbad || d_fbad) begin
          perr_d = perr_q | d_pbad;
          ferr_d = ferr_q | d_fbad;
        end else if (arm_d) begin
          perr_d = 1'b0;
          ferr_d = 1'b0;
          ovr_d  = 1'b0;
          arm_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
      arm_q  <= arm_d;
    end
  end

  assign rdata   = data_q;
  assign rx_full = full_q;
  assign perr    = perr_q;
  assign ferr    = ferr_q;
  assign ovr     = ovr_q;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              dcd_n,
  input  logic              term_en,
  input  logic              echo_en,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_full,
  output logic              perr,
  output logic              ferr,
  output logic              ovr,
  output logic              echo_txd
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_out;
  logic rxd_s;
  logic dcd_s;
  logic rx_en;
  logic frm_done;
  logic [DATA_W-1:0] frm_data;
  logic frm_pbad;
  logic frm_fbad;

  assign raw_in = {dcd_n, rxd};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[g]),
      .q    (sync_out[g])
    );
  end

  assign rxd_s = sync_out[0];
  assign dcd_s = sync_out[1];
  assign rx_en = term_en & ~dcd_s;

  serial_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .rx_en   (rx_en),
    .rxd     (rxd_s),
    .wlen_sel(wlen_sel),
    .par_en  (par_en),
    .par_mode(par_mode),
    .done    (frm_done),
    .data    (frm_data),
    .pbad    (frm_pbad),
    .fbad    (frm_fbad)
  );

  serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (frm_done),
    .d_data   (frm_data),
    .d_pbad   (frm_pbad),
    .d_fbad   (frm_fbad),
    .rd_strobe(rd_strobe),
    .rdata    (rdata),
    .rx_full  (rx_full),
    .perr     (perr),
    .ferr     (ferr),
    .ovr      (ovr)
  );

  assign echo_txd = (echo_en && rx_en) ? rxd_s : 1'b1;

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rd_strobe,
  input logic              frm_done,
  input logic              rx_full,
  input logic              perr,
  input logic              ferr,
  input logic              ovr,
  input logic [DATA_W-1:0] rdata
);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !frm_done |=> !rx_full);

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frm_done));

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && rx_full && !rd_strobe |=> ovr && $stable(rdata));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |=> $stable({perr, ferr, ovr}));

  // R9
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frm_done);

endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .rd_strobe(rd_strobe),
  .frm_done (frm_done),
  .rx_full  (rx_full),
  .perr     (perr),
  .ferr     (ferr),
  .ovr      (ovr),
  .rdata    (rdata)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;

  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n;
  logic tick16;
  logic rxd, dcd_n, term_en, echo_en, par_en, rd_strobe;
  logic [1:0] wlen_sel, par_mode;
  logic [7:0] rdata;
  logic rx_full, perr, ferr, ovr, echo_txd;

  int checks = 0;
  int errors = 0;
  int tdiv_cnt = 0;
  bit done_run = 1'b0;

  logic [7:0] q_data[$];
  logic [2:0] q_flags[$];
  string      q_req[$];
  bit m_perr = 0, m_ferr = 0, m_ovr = 0, m_arm = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick16   <= rst_n && (tdiv_cnt == TDIV - 1);
  end

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .dcd_n(dcd_n),
    .term_en(term_en), .echo_en(echo_en), .wlen_sel(wlen_sel),
    .par_en(par_en), .par_mode(par_mode), .rd_strobe(rd_strobe),
    .rdata(rdata), .rx_full(rx_full), .perr(perr), .ferr(ferr),
    .ovr(ovr), .echo_txd(echo_txd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: compares each loaded character against the queue
  initial begin
    bit seen = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rx_full && !seen) begin
        seen = 1'b1;
        if (q_data.size() == 0) begin
          chk(1'b0, "R6", "unexpected load", int'(rdata), 0);
        end else begin
          logic [7:0] ed;
          logic [2:0] ef;
          string r;
          ed = q_data.pop_front();
          ef = q_flags.pop_front();
          r  = q_req.pop_front();
          chk(rdata == ed, r, "data", int'(rdata), int'(ed));
          chk({perr, ferr, ovr} == ef, r, "flags{p,f,o}",
              int'({perr, ferr, ovr}), int'(ef));
        end
      end
      if (!rx_full) seen = 1'b0;
    end
  end

  task automatic drive_bit(input logic lvl);
    rxd = lvl;
    repeat (BITCLK) @(negedge clk);
  endtask

  // kind: 0 ignored, 1 loaded, 2 overrun
  task automatic send_frame(input logic [7:0] d, input bit flip,
                            input bit stop_lvl, input int kind, input string req);
    int nb;
    logic [7:0] md;
    logic pbit;
    bit pbad;
    nb = 8 - int'(wlen_sel);
    md = d & ((8'd1 << nb) - 8'd1);
    if (nb == 8) md = d;
    case (par_mode)
      2'b00:   pbit = ~(^md);
      2'b01:   pbit = ^md;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    pbit = pbit ^ flip;
    pbad = par_en && !par_mode[1] && flip;
    if (kind == 1) begin
      if (pbad || !stop_lvl) begin
        m_perr = m_perr | pbad;
        m_ferr = m_ferr | !stop_lvl;
      end else if (m_arm) begin
        m_perr = 0; m_ferr = 0; m_ovr = 0; m_arm = 0;
      end
      q_data.push_back(md);
      q_flags.push_back({m_perr, m_ferr, m_ovr});
      q_req.push_back(req);
    end else if (kind == 2) begin
      m_ovr = 1;
    end
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(md[i]);
    if (par_en) drive_bit(pbit);
    drive_bit(stop_lvl);
    drive_bit(1'b1);
  endtask

  task automatic read_rx(input string req);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    m_arm = 1;
    chk(rx_full == 1'b0, req, "rx_full after read", int'(rx_full), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      chk(1'b0, "watchdog", "timeout", 0, 1);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; dcd_n = 1'b0; term_en = 1'b1; echo_en = 1'b0;
    wlen_sel = 2'b00; par_en = 1'b0; par_mode = 2'b00; rd_strobe = 1'b0;
    tick16 = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(rx_full == 0, "R12", "rx_full", int'(rx_full), 0);
    chk({perr, ferr, ovr} == 3'b000, "R12", "flags", int'({perr, ferr, ovr}), 0);
    chk(echo_txd == 1, "R12", "echo_txd", int'(echo_txd), 1);
    drive_bit(1'b1); drive_bit(1'b1);

    // R1 8-bit, no parity, LSB first
    send_frame(8'hA5, 0, 1, 1, "R1");
    read_rx("R6");
    // R3 7-bit even parity, good
    wlen_sel = 2'b01; par_en = 1'b1; par_mode = 2'b01;
    send_frame(8'h5A, 0, 1, 1, "R3");
    read_rx("R6");
    // R3 5-bit odd parity, bad parity bit
    wlen_sel = 2'b11; par_mode = 2'b00;
    send_frame(8'h13, 1, 1, 1, "R3");
    read_rx("R6");
    // R8 flag survives the read
    chk(perr == 1, "R8", "perr after read", int'(perr), 1);
    // R8 good 6-bit odd char clears flags
    wlen_sel = 2'b10;
    send_frame(8'h2C, 0, 1, 1, "R8");
    read_rx("R6");
    // R4 mark and space ignore parity value
    wlen_sel = 2'b00; par_mode = 2'b10;
    send_frame(8'h81, 1, 1, 1, "R4");
    read_rx("R6");
    par_mode = 2'b11;
    send_frame(8'h7F, 1, 1, 1, "R4");
    read_rx("R6");
    // R5 framing error
    par_en = 1'b0;
    send_frame(8'hC3, 0, 0, 1, "R5");
    read_rx("R6");
    send_frame(8'h3C, 0, 1, 1, "R8");
    read_rx("R6");
    // R7 overrun
    send_frame(8'h11, 0, 1, 1, "R7");
    send_frame(8'h22, 0, 1, 2, "R7");
    chk(ovr == 1, "R7", "ovr", int'(ovr), 1);
    chk(rdata == 8'h11, "R7", "rdata kept", int'(rdata), 8'h11);
    read_rx("R6");
    send_frame(8'h33, 0, 1, 1, "R8");
    read_rx("R6");
    // R2 short low pulse is noise
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(rx_full == 0, "R2", "rx_full after glitch", int'(rx_full), 0);
    send_frame(8'h7E, 0, 1, 1, "R2");
    read_rx("R6");
    // R9 carrier absent
    dcd_n = 1'b1;
    drive_bit(1'b1);
    send_frame(8'h44, 0, 1, 0, "R9");
    drive_bit(1'b1);
    chk(rx_full == 0, "R9", "rx_full with dcd_n high", int'(rx_full), 0);
    dcd_n = 1'b0;
    drive_bit(1'b1);
    // R10 terminal enable off
    term_en = 1'b0;
    send_frame(8'h55, 0, 1, 0, "R10");
    drive_bit(1'b1);
    chk(rx_full == 0, "R10", "rx_full with term_en low", int'(rx_full), 0);
    term_en = 1'b1;
    drive_bit(1'b1);
    // R11 echo
    echo_en = 1'b1;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk(echo_txd == 0, "R11", "echo low", int'(echo_txd), 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk(echo_txd == 1, "R11", "echo high", int'(echo_txd), 1);
    echo_en = 1'b0;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk(echo_txd == 1, "R11", "echo off", int'(echo_txd), 1);
    rxd = 1'b1;
    drive_bit(1'b1); drive_bit(1'b1);
    chk(q_data.size() == 0, "R6", "pending items", q_data.size(), 0);
    done_run = 1'b1;
    report();
  end

endmodule